// File: doc/BRIEF.md
# Line-Locked Pixel Clock Synthesiser

This block produces a pixel-rate clock enable inside a fast system clock domain and slaves that rate to an incoming horizontal sync pulse. A phase accumulator adds an increment every fast cycle, and each carry out of the accumulator marks one pixel. A divide-by-two stage can be placed after the carry when low pixel rates are needed. The pixel pulses then drive a line counter that completes once per programmed number of pixels per line.

A phase-frequency detector measures, in fast cycles, how far the line counter's completion sits from the sync edge. It produces a signed error once per line. A proportional-plus-integral filter turns that error into a correction. The correction is added to the nominal increment, and the result is clamped to the legal range before it reaches the accumulator. A lock flag reports when the measured error has stayed small for a run of consecutive lines.

The sync input is assumed to be already qualified and synchronous to the fast clock. It is a single-cycle pulse.

Top module: `line_lock_pll`

## Requirements
- R1: While reset is held, `pix_en` and `locked` are 0. After reset the integral term is zero, so with no sync pulses the pixel rate equals the nominal rate exactly.
- R2: The accumulator is ACC_W bits wide. Each carry out gives a one-cycle `pix_en` pulse. With no sync pulses, the pulse count over 2^ACC_W cycles equals `nom_inc` (divider off).
- R3: When `div_sel` is 1, only every second carry produces a pulse, starting with the first. This halves the rate, and no two pulses fall in adjacent cycles.
- R4: The line counter counts `pix_en` pulses from reset and completes a line on every `term_cnt`-th pulse. The completion event is seen by the detector in the cycle after that pulse. `term_cnt` must be at least 2.
- R5: The detector samples the line counter when a sync pulse arrives. If the count is at least `term_cnt`/2, the error is the positive number of cycles from the sync until the next line completion. Otherwise it is minus the number of cycles since the last completion. The error is clamped to a signed ERR_W range.
- R6: A sync pulse seen in the same cycle as a line completion yields an error of exactly zero.
- R7: A gain code k scales its path by an arithmetic right shift of (2^GAIN_W − 1 − k) bits. With the default 3-bit codes, code 7 applies the error unshifted and code 0 shifts it by 7.
- R8: The proportional term holds only the latest scaled error. The integral term adds each new scaled error and keeps its value between updates, saturating instead of wrapping.
- R9: The increment applied is `nom_inc` plus both terms, clamped to the range 1 to 2^ACC_W − 1.
- R10: `locked` rises after LOCK_LINES consecutive errors whose magnitude is below LOCK_THR. It falls on the first error at or above LOCK_THR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_sync | input | 1 | Qualified sync pulse, one cycle wide |
| nom_inc | input | ACC_W | Nominal accumulator increment |
| term_cnt | input | TC_W | Pixels per line (at least 2) |
| kp | input | GAIN_W | Proportional gain code |
| ki | input | GAIN_W | Integral gain code |
| div_sel | input | 1 | 1 inserts the divide-by-two after the carry |
| pix_en | output | 1 | One-cycle pixel enable pulse |
| locked | output | 1 | Loop lock indication |

## Verification
The sync pulse and the line-completion event can land in the same cycle. The detector must then report zero rather than open a measurement towards the next line. The bench provokes this by tracking the pixel pulse count itself and timing the sync to coincide with the completion after the `term_cnt`-th pulse, with both gain codes at maximum. Any nonzero error would shift the rate over a 4096-cycle window, so the bench judges the case by requiring the exact nominal pulse count. The same coincident sync is also used to clear a held proportional term while an integral term stays in place.

// File: rtl/lpll_pkg.sv
package lpll_pkg;

   // detector state: idle, or waiting for a line completion after an early sync
   typedef enum logic {
      PD_IDLE = 1'b0,
      PD_WAIT = 1'b1
   } pd_state_t;

   function automatic int pick_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lpll_dto.sv
module lpll_dto #(
   parameter int ACC_W   = 32,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] inc,
   input  logic             div_en,
   output logic             pix_en
);

   logic [ACC_W-1:0] acc;
   logic [ACC_W:0]   sum;
   logic             carry;
   logic             pass;

   assign sum   = {1'b0, acc} + {1'b0, inc};
   assign carry = sum[ACC_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc    <= '0;
         pix_en <= 1'b0;
      end else begin
         acc    <= sum[ACC_W-1:0];
         pix_en <= carry & pass;
      end
   end

   generate
      if (HAS_DIV) begin : g_div
         logic skip_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       skip_q <= 1'b0;
            else if (!div_en) skip_q <= 1'b0;
            else if (carry)   skip_q <= ~skip_q;
         end
         assign pass = !div_en || !skip_q;

         // R3: halved output never produces back-to-back pulses
         p_div_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_en && div_en) |=> !(pix_en && div_en));
      end else begin : g_nodiv
         logic div_unused;
         assign div_unused = div_en;
         assign pass       = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/lpll_pfd.sv
module lpll_pfd
   import lpll_pkg::*;
#(
   parameter int TC_W       = 12,
   parameter int ERR_W      = 16,
   parameter int LOCK_LINES = 16,
   parameter int LOCK_THR   = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pix_en,
   input  logic                    ref_i,
   input  logic [TC_W-1:0]         term_cnt,
   output logic signed [ERR_W-1:0] err_o,
   output logic                    upd_o,
   output logic                    lock_o
);

   localparam int MW = ERR_W - 1;
   localparam logic [MW-1:0] M_MAX = '1;
   localparam int LW = $clog2(LOCK_LINES + 1);

   logic [TC_W-1:0] fb_cnt;
   logic [TC_W-1:0] half_cnt;
   logic            wrap_r;
   logic [MW-1:0]   since_wrap;
   logic [MW-1:0]   meas;
   pd_state_t       st;
   logic [LW-1:0]   good_cnt;
   logic [ERR_W-1:0] mag;

   assign half_cnt = term_cnt >> 1;

   // line counter on pixel pulses
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fb_cnt <= '0;
         wrap_r <= 1'b0;
      end else begin
         wrap_r <= 1'b0;
         if (pix_en) begin
            if (fb_cnt >= term_cnt - 1'b1) begin
               fb_cnt <= '0;
               wrap_r <= 1'b1;
            end else begin
               fb_cnt <= fb_cnt + 1'b1;
            end
         end
      end
   end

   // cycles since the last line completion, saturating
   always_ff @(posedge clk) begin
      if (!rst_n)                   since_wrap <= M_MAX;
      else if (wrap_r)              since_wrap <= MW'(1);
      else if (since_wrap != M_MAX) since_wrap <= since_wrap + 1'b1;
   end

   // phase-frequency detector
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= PD_IDLE;
         meas  <= '0;
         err_o <= '0;
         upd_o <= 1'b0;
      end else begin
         upd_o <= 1'b0;
         if (meas != M_MAX) meas <= meas + 1'b1;
         if (ref_i && wrap_r) begin
            err_o <= '0;
            upd_o <= 1'b1;
            st    <= PD_IDLE;
         end else if (ref_i) begin
            if (fb_cnt < half_cnt) begin
               err_o <= -$signed({1'b0, since_wrap});
               upd_o <= 1'b1;
               st    <= PD_IDLE;
            end else begin
               st   <= PD_WAIT;
               meas <= MW'(1);
            end
         end else if (wrap_r && st == PD_WAIT) begin
            err_o <= $signed({1'b0, meas});
            upd_o <= 1'b1;
            st    <= PD_IDLE;
         end
      end
   end

   // lock qualification
   assign mag = err_o[ERR_W-1] ? -err_o : err_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         good_cnt <= '0;
      end else if (upd_o) begin
         if (mag < ERR_W'(LOCK_THR)) begin
            if (good_cnt != LW'(LOCK_LINES)) good_cnt <= good_cnt + 1'b1;
         end else begin
            good_cnt <= '0;
         end
      end
   end

   assign lock_o = (good_cnt == LW'(LOCK_LINES));

   // R4: a line completes only right after a pixel pulse
   p_wrap_after_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_r |-> $past(pix_en));

   // R6: coincident sync and completion report zero
   p_coincide_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_i && wrap_r) |=> (upd_o && err_o == '0));

   // R10: a large error drops lock at once
   p_lock_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_o && mag >= ERR_W'(LOCK_THR)) |=> !lock_o);

endmodule

// File: rtl/lpll_pi.sv
module lpll_pi
   import lpll_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int ERR_W  = 16,
   parameter int GAIN_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd,
   input  logic signed [ERR_W-1:0] err,
   input  logic [GAIN_W-1:0]       kp,
   input  logic [GAIN_W-1:0]       ki,
   input  logic [ACC_W-1:0]        nom,
   output logic [ACC_W-1:0]        inc_eff
);

   localparam int IW = pick_max(ACC_W, ERR_W) + 1;
   localparam int SW = IW + 2;
   localparam logic [GAIN_W-1:0] K_MAX = '1;
   localparam logic signed [SW-1:0] INC_MAX = $signed(SW'({ACC_W{1'b1}}));
   localparam logic signed [SW-1:0] INC_MIN = $signed(SW'(1));

   logic signed [IW-1:0] err_x;
   logic signed [IW-1:0] p_prop;
   logic signed [IW-1:0] p_int;
   logic signed [IW-1:0] prop_r;
   logic signed [IW-1:0] integ;
   logic signed [IW:0]   isum;
   logic signed [IW-1:0] isat;
   logic signed [SW-1:0] tot;
   logic [ACC_W-1:0]     inc_next;

   assign err_x  = IW'(err);
   assign p_prop = err_x >>> (K_MAX - kp);
   assign p_int  = err_x >>> (K_MAX - ki);
   assign isum   = {integ[IW-1], integ} + {p_int[IW-1], p_int};

   always_comb begin
      if (isum[IW] != isum[IW-1])
         isat = isum[IW] ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}};
      else
         isat = isum[IW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prop_r <= '0;
         integ  <= '0;
      end else if (upd) begin
         prop_r <= p_prop;
         integ  <= isat;
      end
   end

   assign tot = SW'($signed({1'b0, nom})) + SW'(prop_r) + SW'(integ);

   always_comb begin
      if (tot < INC_MIN)      inc_next = ACC_W'(1);
      else if (tot > INC_MAX) inc_next = {ACC_W{1'b1}};
      else                    inc_next = tot[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) inc_eff <= ACC_W'(1);
      else        inc_eff <= inc_next;
   end

   // R8: integral term only moves on a detector update
   p_integ_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(integ));

endmodule

// File: rtl/line_lock_pll.sv
module line_lock_pll #(
   parameter int ACC_W      = 32,
   parameter int TC_W       = 12,
   parameter int ERR_W      = 16,
   parameter int GAIN_W     = 3,
   parameter int LOCK_LINES = 16,
   parameter int LOCK_THR   = 8,
   parameter bit HAS_DIV    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_sync,
   input  logic [ACC_W-1:0]  nom_inc,
   input  logic [TC_W-1:0]   term_cnt,
   input  logic [GAIN_W-1:0] kp,
   input  logic [GAIN_W-1:0] ki,
   input  logic              div_sel,
   output logic              pix_en,
   output logic              locked
);

   generate
      if (ACC_W < 4 || ERR_W < 4 || TC_W < 2 || GAIN_W < 1 ||
          LOCK_LINES < 1 || LOCK_THR < 1) begin : g_bad_param
         $error("line_lock_pll: parameter out of range");
      end
   endgenerate

   logic [ACC_W-1:0]        inc_eff;
   logic signed [ERR_W-1:0] pd_err;
   logic                    pd_upd;

   lpll_dto #(
      .ACC_W   (ACC_W),
      .HAS_DIV (HAS_DIV)
   ) u_dto (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc_eff),
      .div_en (div_sel),
      .pix_en (pix_en)
   );

   lpll_pfd #(
      .TC_W       (TC_W),
      .ERR_W      (ERR_W),
      .LOCK_LINES (LOCK_LINES),
      .LOCK_THR   (LOCK_THR)
   ) u_pfd (
      .clk      (clk),
      .rst_n    (rst_n),
      .pix_en   (pix_en),
      .ref_i    (ref_sync),
      .term_cnt (term_cnt),
      .err_o    (pd_err),
      .upd_o    (pd_upd),
      .lock_o   (locked)
   );

   lpll_pi #(
      .ACC_W  (ACC_W),
      .ERR_W  (ERR_W),
      .GAIN_W (GAIN_W)
   ) u_pi (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (pd_upd),
      .err     (pd_err),
      .kp      (kp),
      .ki      (ki),
      .nom     (nom_inc),
      .inc_eff (inc_eff)
   );

endmodule

// File: tb/sim_line_lock_pll.sv
module sim_line_lock_pll;

   localparam int CLK_P = 10;
   localparam int AW    = 12;
   localparam int TW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_sync = 1'b0;
   logic [AW-1:0] nom_inc = AW'(1024);
   logic [TW-1:0] term_cnt = TW'(8);
   logic [2:0]    kp = 3'd0;
   logic [2:0]    ki = 3'd0;
   logic          div_sel = 1'b0;
   logic          pix_en;
   logic          locked;

   int n_chk = 0;
   int n_bad = 0;
   int pcnt  = 0;

   always #(CLK_P/2) clk = ~clk;

   line_lock_pll #(
      .ACC_W      (AW),
      .TC_W       (TW),
      .ERR_W      (16),
      .GAIN_W     (3),
      .LOCK_LINES (16),
      .LOCK_THR   (8),
      .HAS_DIV    (1'b1)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_sync (ref_sync),
      .nom_inc  (nom_inc),
      .term_cnt (term_cnt),
      .kp       (kp),
      .ki       (ki),
      .div_sel  (div_sel),
      .pix_en   (pix_en),
      .locked   (locked)
   );

   task automatic chk_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (pix_en) pcnt++;
   endtask

   task automatic do_reset();
      rst_n    = 1'b0;
      ref_sync = 1'b0;
      for (int i = 0; i < 3; i++) step();
      chk_eq("R1 pix_en in reset", int'(pix_en), 0);
      chk_eq("R1 locked in reset", int'(locked), 0);
      rst_n = 1'b1;
      pcnt  = 0;
   endtask

   // wait until the observed pulse index leaves remainder r modulo m
   task automatic wait_pix(input int r, input int m);
      do step(); while (!(pix_en && (pcnt % m) == r));
   endtask

   // sync seen by the design two edges after the pulse just observed
   task automatic pulse_ref();
      step();
      ref_sync = 1'b1;
      step();
      ref_sync = 1'b0;
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic count_win(input int n, output int c);
      int start;
      start = pcnt;
      for (int i = 0; i < n; i++) step();
      c = pcnt - start;
   endtask

   task automatic t_free_run();
      int c;
      do_reset();
      nom_inc = AW'(1024); div_sel = 1'b0; kp = 3'd0; ki = 3'd0; term_cnt = TW'(8);
      settle(20);
      count_win(4096, c);
      chk_eq("R2 free run inc 1024", c, 1024);
      nom_inc = AW'(512);
      settle(20);
      count_win(4096, c);
      chk_eq("R2 free run inc 512", c, 512);
   endtask

   task automatic t_divider();
      int c;
      do_reset();
      nom_inc = AW'(1024); div_sel = 1'b1;
      settle(20);
      count_win(4096, c);
      chk_eq("R3 halved rate", c, 512);
      div_sel = 1'b0;
   endtask

   task automatic t_lock();
      do_reset();
      nom_inc = AW'(1024); kp = 3'd0; ki = 3'd0; term_cnt = TW'(8);
      for (int l = 0; l < 10; l++) begin
         wait_pix(7, 8);
         pulse_ref();
      end
      settle(40);
      chk_eq("R10 not yet locked after 10 lines", int'(locked), 0);
      for (int l = 0; l < 10; l++) begin
         wait_pix(7, 8);
         pulse_ref();
      end
      settle(40);
      chk_eq("R10 R4 locked after 20 aligned lines", int'(locked), 1);
      wait_pix(4, 8);
      pulse_ref();
      settle(40);
      chk_eq("R10 lock drops on large error", int'(locked), 0);
   endtask

   task automatic t_coincide();
      int c;
      do_reset();
      nom_inc = AW'(1024); kp = 3'd7; ki = 3'd7; term_cnt = TW'(8);
      settle(20);
      wait_pix(0, 8);
      pulse_ref();
      settle(60);
      count_win(4096, c);
      chk_eq("R6 coincident sync gives zero error", c, 1024);
   endtask

   task automatic t_prop();
      int c;
      do_reset();
      nom_inc = AW'(1024); kp = 3'd7; ki = 3'd0; term_cnt = TW'(8);
      wait_pix(4, 8);
      pulse_ref();
      settle(60);
      count_win(4096, c);
      chk_rng("R5 R9 early sync raises rate by +16", c, 1038, 1042);
      wait_pix(0, 8);
      pulse_ref();
      settle(60);
      count_win(4096, c);
      chk_eq("R8 proportional term replaced by zero error", c, 1024);
   endtask

   task automatic t_low_gain();
      int c;
      do_reset();
      nom_inc = AW'(1024); kp = 3'd2; ki = 3'd2; term_cnt = TW'(8);
      wait_pix(4, 8);
      pulse_ref();
      settle(60);
      count_win(4096, c);
      chk_eq("R7 code 2 shifts error 16 to zero", c, 1024);
   endtask

   task automatic t_integral();
      int c;
      do_reset();
      nom_inc = AW'(1024); kp = 3'd0; ki = 3'd7; term_cnt = TW'(8);
      wait_pix(4, 8);
      pulse_ref();
      settle(60);
      wait_pix(0, 8);
      pulse_ref();
      settle(60);
      count_win(4096, c);
      chk_rng("R8 integral held after zero error", c, 1038, 1042);
      wait_pix(4, 8);
      pulse_ref();
      settle(60);
      count_win(4096, c);
      chk_rng("R8 integral accumulates second error", c, 1052, 1058);
      do_reset();
      ki = 3'd0;
      settle(20);
      count_win(4096, c);
      chk_eq("R1 integral cleared by reset", c, 1024);
   endtask

   task automatic t_sat_high();
      int c;
      do_reset();
      nom_inc = AW'(4094); kp = 3'd7; ki = 3'd0; term_cnt = TW'(8);
      wait_pix(4, 8);
      pulse_ref();
      settle(60);
      count_win(512, c);
      chk_rng("R9 increment clamps at maximum", c, 510, 512);
   endtask

   task automatic t_sat_low();
      int c;
      do_reset();
      nom_inc = AW'(2); kp = 3'd7; ki = 3'd0; term_cnt = TW'(2);
      wait_pix(0, 2);
      settle(3);
      pulse_ref();
      settle(60);
      count_win(4096, c);
      chk_rng("R5 R9 late sync negative error clamps increment to 1", c, 0, 2);
   endtask

   initial begin
      t_free_run();
      t_divider();
      t_lock();
      t_coincide();
      t_prop();
      t_low_gain();
      t_integral();
      t_sat_high();
      t_sat_low();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule